// File: doc/BRIEF.md
# Dual-Space SPI Register Target

This block is an SPI target that gives a host access to two byte-wide register spaces behind one serial link. A small space of up to 64 registers is reached with a one-byte command. A larger space of up to 1024 locations, which holds the transmit and receive frame buffers, is reached with a two-byte command. The most significant bit of the first command byte selects the format. After the command, every further byte in the same chip-select window is a data byte for the next address. The address steps up by one per byte, so a complete frame buffer can be written or read in a single burst.

The serial inputs are brought into the system clock domain by synchronisers, and the protocol runs entirely on that clock. On the inside the block drives a simple register port: a one-cycle write strobe with address and data, or a one-cycle read strobe whose data the register file returns one clock later. The block does not define the meaning of any register. The transmit buffer starts at long address 0x000 and the receive buffer at 0x300, but the block treats both as ordinary byte locations.

Top module: `spi_dual_regslave`

## Requirements
- R1: A first command byte with bit 7 = 0 is a short command: bits [6:1] hold the register address and bit 0 selects a write (1) or a read (0). The resulting strobes carry reg_long = 0 and an address below 2^SHORT_AW.
- R2: A first command byte with bit 7 = 1 opens a 16-bit long command. Command bits [14:5] hold the address and bit 4 selects a write (1) or a read (0). Bits [3:0] have no effect, and the strobes carry reg_long = 1.
- R3: In a write access, each complete data byte after the command gives exactly one reg_wr_en pulse carrying that byte. The first byte goes to the command address and each later byte goes to the previous address plus one.
- R4: In a read access, the byte stored at the command address is shifted out on MISO, MSB first, during the byte that follows the command. Each further byte returns the next address. A reg_rd_en pulse is issued when the command completes and again when each data byte completes, each for the next address in turn. reg_rdata must hold the addressed byte one clock after the strobe.
- R5: Auto-increment wraps to zero at the top of the active space: short address 63 is followed by 0, and long address 1023 is followed by 0.
- R6: SPI mode 0 with the system clock at least 8 times the SCK frequency. MOSI is captured on the SCK rising edge, MISO changes after the falling edge, and each new byte's MSB is on MISO before that byte's first rising edge.
- R7: Deasserting CS_n discards a partly received byte and returns the parser to command decoding. A partial data byte causes no write, and the next window is decoded afresh.
- R8: MISO is 0 while CS_n is high, during command bytes, and during the data bytes of a write access.
- R9: After reset, MISO is 0 and neither register strobe is active.
- R10: reg_wr_en and reg_rd_en are single-cycle pulses and are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCK |
| rst_n | input | 1 | Asynchronous-assert active-low reset, sampled synchronously |
| sck | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 when idle |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_rd_en | output | 1 | One-cycle register read strobe |
| reg_long | output | 1 | 1 when the strobe targets the long space |
| reg_addr | output | LONG_AW | Register address for the current strobe |
| reg_wdata | output | 8 | Write data for reg_wr_en |
| reg_rdata | input | 8 | Read data, valid one clock after reg_rd_en |

## Verification
The bench targets the address-wrap points at 63 and 1023. A design that carries into the wrong width would write or read a neighbour of the expected location after the top, or step into a 7-bit short address. Long commands are sent with non-zero don't-care bits, which catches a design that takes its address from the wrong field or decodes bit 4 wrongly. Chip select is dropped in the middle of command and data bytes, so a parser that keeps stale bits produces a stray write or misreads the next command. Every read byte is compared at the SCK edge where the host samples it, so a design that loads the next byte late shifts out the previous value or a bit-rotated one.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
   localparam int BYTE_W   = 8;
   localparam int CNT_W    = $clog2(BYTE_W);
   // command field positions used by the decoder
   localparam int FMT_BIT  = 7;   // first byte: 1 = long format
   localparam int SWR_BIT  = 0;   // short command write flag
   localparam int LWR_BIT  = 4;   // second long byte write flag

   typedef enum logic [1:0] {
      PH_CMD0 = 2'd0,
      PH_CMD1 = 2'd1,
      PH_DATA = 2'd2
   } phase_t;
endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic mosi,
   output logic sck_rise,
   output logic sck_fall,
   output logic cs_act,
   output logic mosi_s
);
   localparam int NSIG = 3;

   logic [NSIG-1:0] raw;
   logic [NSIG-1:0] sy;
   logic            sck_prev;

   assign raw = {cs_n, mosi, sck};

   genvar g;
   generate
      for (g = 0; g < NSIG; g++) begin : g_chain
         localparam logic RST_VAL = (g == NSIG - 1);
         logic [SYNC_STAGES-1:0] ch;
         always_ff @(posedge clk) begin
            if (!rst_n) ch <= {SYNC_STAGES{RST_VAL}};
            else        ch <= {ch[SYNC_STAGES-2:0], raw[g]};
         end
         assign sy[g] = ch[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sy[0];
   end

   assign sck_rise = sy[0] & ~sck_prev;
   assign sck_fall = ~sy[0] & sck_prev;
   assign mosi_s   = sy[1];
   assign cs_act   = ~sy[2];
endmodule

// File: rtl/spi_rs_shifter.sv
module spi_rs_shifter
   import spi_rs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              cs_act,
   input  logic              mosi_s,
   input  logic              load_stb,
   input  logic [BYTE_W-1:0] load_data,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val,
   output logic              miso
);
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-1:0] rx_sh;
   logic [BYTE_W-1:0] tx_sh;
   logic [BYTE_W-1:0] tx_next;
   logic              byte_edge;

   always_ff @(posedge clk) begin
      if (!rst_n || !cs_act) begin
         bitcnt    <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         tx_next   <= '0;
         byte_edge <= 1'b0;
         byte_done <= 1'b0;
         byte_val  <= '0;
      end else begin
         byte_done <= 1'b0;
         if (load_stb) tx_next <= load_data;
         if (sck_rise) begin
            rx_sh  <= {rx_sh[BYTE_W-2:0], mosi_s};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == CNT_W'(BYTE_W - 1)) begin
               byte_done <= 1'b1;
               byte_val  <= {rx_sh[BYTE_W-2:0], mosi_s};
               byte_edge <= 1'b1;
            end
         end
         if (sck_fall) begin
            if (byte_edge) begin
               tx_sh     <= load_stb ? load_data : tx_next;
               tx_next   <= '0;
               byte_edge <= 1'b0;
            end else begin
               tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assign miso = cs_act & tx_sh[BYTE_W-1];
endmodule

// File: rtl/spi_rs_seq.sv
module spi_rs_seq
   import spi_rs_pkg::*;
#(
   parameter int SHORT_AW = 6,
   parameter int LONG_AW  = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_act,
   input  logic               byte_done,
   input  logic [BYTE_W-1:0]  byte_val,
   output logic               reg_wr_en,
   output logic               reg_rd_en,
   output logic               reg_long,
   output logic [LONG_AW-1:0] reg_addr,
   output logic [BYTE_W-1:0]  reg_wdata,
   output logic               load_stb
);
   localparam logic [LONG_AW-1:0] SHORT_MASK = LONG_AW'((1 << SHORT_AW) - 1);
   localparam logic [LONG_AW-1:0] LONG_MASK  = '1;

   phase_t             phase;
   logic               is_long;
   logic               is_wr;
   logic [6:0]         hi_bits;
   logic [LONG_AW-1:0] addr;
   logic [LONG_AW-1:0] s_addr;
   logic [LONG_AW-1:0] l_addr;
   logic [9:0]         l_full;

   function automatic logic [LONG_AW-1:0] step(input logic [LONG_AW-1:0] a,
                                               input logic lg);
      return (a + 1'b1) & (lg ? LONG_MASK : SHORT_MASK);
   endfunction

   assign s_addr = LONG_AW'(byte_val[6:1]) & SHORT_MASK;
   assign l_full = {hi_bits, byte_val[7:5]};
   assign l_addr = LONG_AW'(l_full);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_CMD0;
         is_long   <= 1'b0;
         is_wr     <= 1'b0;
         hi_bits   <= '0;
         addr      <= '0;
         reg_wr_en <= 1'b0;
         reg_rd_en <= 1'b0;
         reg_long  <= 1'b0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         load_stb  <= 1'b0;
      end else begin
         reg_wr_en <= 1'b0;
         reg_rd_en <= 1'b0;
         load_stb  <= reg_rd_en;
         if (!cs_act) begin
            phase <= PH_CMD0;
         end else if (byte_done) begin
            unique case (phase)
               PH_CMD0: begin
                  if (!byte_val[FMT_BIT]) begin
                     is_long <= 1'b0;
                     is_wr   <= byte_val[SWR_BIT];
                     phase   <= PH_DATA;
                     if (byte_val[SWR_BIT]) begin
                        addr <= s_addr;
                     end else begin
                        reg_rd_en <= 1'b1;
                        reg_long  <= 1'b0;
                        reg_addr  <= s_addr;
                        addr      <= step(s_addr, 1'b0);
                     end
                  end else begin
                     hi_bits <= byte_val[6:0];
                     phase   <= PH_CMD1;
                  end
               end
               PH_CMD1: begin
                  is_long <= 1'b1;
                  is_wr   <= byte_val[LWR_BIT];
                  phase   <= PH_DATA;
                  if (byte_val[LWR_BIT]) begin
                     addr <= l_addr;
                  end else begin
                     reg_rd_en <= 1'b1;
                     reg_long  <= 1'b1;
                     reg_addr  <= l_addr;
                     addr      <= step(l_addr, 1'b1);
                  end
               end
               default: begin
                  reg_wr_en <= is_wr;
                  reg_rd_en <= ~is_wr;
                  reg_long  <= is_long;
                  reg_addr  <= addr;
                  if (is_wr) reg_wdata <= byte_val;
                  addr      <= step(addr, is_long);
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/spi_dual_regslave.sv
module spi_dual_regslave
   import spi_rs_pkg::*;
#(
   parameter int SHORT_AW    = 6,
   parameter int LONG_AW     = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck,
   input  logic               cs_n,
   input  logic               mosi,
   output logic               miso,
   output logic               reg_wr_en,
   output logic               reg_rd_en,
   output logic               reg_long,
   output logic [LONG_AW-1:0] reg_addr,
   output logic [7:0]         reg_wdata,
   input  logic [7:0]         reg_rdata
);
   generate
      if (SHORT_AW < 1 || SHORT_AW > 6) begin : g_bad_short
         $error("SHORT_AW must fit the 6-bit short command field");
      end
      if (LONG_AW < 1 || LONG_AW > 10) begin : g_bad_long
         $error("LONG_AW must fit the 10-bit long command field");
      end
      if (SHORT_AW > LONG_AW) begin : g_bad_order
         $error("SHORT_AW may not exceed LONG_AW");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              sck_rise, sck_fall, cs_act, mosi_s;
   logic              byte_done, load_stb;
   logic [BYTE_W-1:0] byte_val;

   spi_rs_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .mosi_s(mosi_s)
   );

   spi_rs_shifter i_shift (
      .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
      .cs_act(cs_act), .mosi_s(mosi_s), .load_stb(load_stb),
      .load_data(reg_rdata), .byte_done(byte_done), .byte_val(byte_val),
      .miso(miso)
   );

   spi_rs_seq #(.SHORT_AW(SHORT_AW), .LONG_AW(LONG_AW)) i_seq (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .byte_done(byte_done),
      .byte_val(byte_val), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
      .reg_long(reg_long), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .load_stb(load_stb)
   );
endmodule

// File: rtl/spi_dual_regslave_chk.sv
module spi_dual_regslave_chk #(
   parameter int SHORT_AW = 6,
   parameter int LONG_AW  = 10
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cs_n,
   input logic               miso,
   input logic               reg_wr_en,
   input logic               reg_rd_en,
   input logic               reg_long,
   input logic [LONG_AW-1:0] reg_addr
);
   localparam logic [LONG_AW-1:0] S_MAX = LONG_AW'((1 << SHORT_AW) - 1);

   logic [2:0]         hi_cnt;
   logic               wr_seen;
   logic               prev_long;
   logic [LONG_AW-1:0] prev_addr;
   logic [LONG_AW-1:0] want_addr;

   always_ff @(posedge clk) begin
      if (!rst_n)            hi_cnt <= '0;
      else if (!cs_n)        hi_cnt <= '0;
      else if (hi_cnt != 3'd7) hi_cnt <= hi_cnt + 3'd1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || cs_n) begin
         wr_seen   <= 1'b0;
         prev_long <= 1'b0;
         prev_addr <= '0;
      end else if (reg_wr_en) begin
         wr_seen   <= 1'b1;
         prev_long <= reg_long;
         prev_addr <= reg_addr;
      end
   end

   assign want_addr = (prev_addr + 1'b1) & (prev_long ? {LONG_AW{1'b1}} : S_MAX);

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && reg_rd_en));                                  // R10
   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en |=> !reg_wr_en);                                   // R3
   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_en |=> !reg_rd_en);                                   // R4
   AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_wr_en || reg_rd_en) && !reg_long) |-> (reg_addr <= S_MAX)); // R1
   AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && wr_seen) |-> (reg_addr == want_addr && reg_long == prev_long)); // R5
   AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt >= 3'd4) |-> !miso);                                 // R8
   AST_NO_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_cnt >= 3'd4) |-> (!reg_wr_en && !reg_rd_en));            // R7
endmodule

bind spi_dual_regslave spi_dual_regslave_chk #(
   .SHORT_AW(SHORT_AW), .LONG_AW(LONG_AW)
) i_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso),
   .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
   .reg_long(reg_long), .reg_addr(reg_addr)
);

// File: tb/test_spi_dual_regslave.sv
module test_spi_dual_regslave;
   localparam int HP  = 4;    // SCK half period in system clocks
   localparam int LAW = 10;

   logic           clk = 1'b0;
   logic           rst_n, sck, cs_n, mosi;
   logic           miso, reg_wr_en, reg_rd_en, reg_long;
   logic [LAW-1:0] reg_addr;
   logic [7:0]     reg_wdata;
   logic [7:0]     reg_rdata = 8'h00;

   always #10 clk = ~clk;

   spi_dual_regslave i_spi_dual_regslave (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
      .miso(miso), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
      .reg_long(reg_long), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   int          vectors = 0;
   int          miscompares = 0;
   logic [7:0]  sh_mem [64];
   logic [7:0]  lg_mem [1024];
   logic [18:0] exp_wq [$];
   logic [10:0] exp_rq [$];
   logic [7:0]  wbuf   [$];

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   // register file model and strobe comparison against the expected queues
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (reg_wr_en) begin
            if (exp_wq.size() == 0) chk("R7 unexpected write", {reg_long, reg_addr, reg_wdata}, -1);
            else chk("R3 R10 write strobe", {reg_long, reg_addr, reg_wdata}, exp_wq.pop_front());
            if (reg_long) lg_mem[reg_addr] = reg_wdata;
            else          sh_mem[reg_addr[5:0]] = reg_wdata;
         end
         if (reg_rd_en) begin
            if (exp_rq.size() == 0) chk("R4 unexpected read", {reg_long, reg_addr}, -1);
            else chk("R4 R10 read strobe", {reg_long, reg_addr}, exp_rq.pop_front());
            reg_rdata = reg_long ? lg_mem[reg_addr] : sh_mem[reg_addr[5:0]];
         end
      end
   end

   task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
      rx = 8'h00;
      for (int i = 7; i > 7 - nb; i--) begin
         mosi = tx[i];
         repeat (HP) @(negedge clk);
         rx[i] = miso;
         sck = 1'b1;
         repeat (HP) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic cs_start();
      cs_n = 1'b0;
      repeat (HP) @(negedge clk);
   endtask

   task automatic cs_end();
      repeat (HP) @(negedge clk);
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
      chk("R8 miso idle after window", miso, 0);
      chk("R3 writes drained", exp_wq.size(), 0);
      chk("R4 reads drained", exp_rq.size(), 0);
      exp_wq.delete();
      exp_rq.delete();
   endtask

   task automatic send_cmd(input logic [15:0] cmd, input bit lg);
      logic [7:0] rx;
      spi_bits(cmd[15:8], 8, rx);
      chk("R8 miso zero in command", rx, 0);
      if (lg) begin
         spi_bits(cmd[7:0], 8, rx);
         chk("R8 miso zero in command", rx, 0);
      end
   endtask

   task automatic do_write(input bit lg, input int a, input logic [3:0] dc);
      logic [7:0] rx;
      int msk = lg ? 1023 : 63;
      foreach (wbuf[j]) exp_wq.push_back({lg, 10'((a + j) & msk), wbuf[j]});
      cs_start();
      if (lg) send_cmd({1'b1, 10'(a), 1'b1, dc}, 1'b1);
      else    send_cmd({1'b0, 6'(a), 1'b1, 8'h00}, 1'b0);
      foreach (wbuf[j]) begin
         spi_bits(wbuf[j], 8, rx);
         chk("R8 miso zero in write data", rx, 0);
      end
      cs_end();
      wbuf.delete();
   endtask

   task automatic do_read(input bit lg, input int a, input int n, input logic [3:0] dc,
                          input string tag);
      logic [7:0] rx;
      logic [7:0] ev [$];
      int msk = lg ? 1023 : 63;
      for (int j = 0; j < n; j++) ev.push_back(lg ? lg_mem[(a + j) & msk] : sh_mem[(a + j) & msk]);
      for (int j = 0; j <= n; j++) exp_rq.push_back({lg, 10'((a + j) & msk)});
      cs_start();
      if (lg) send_cmd({1'b1, 10'(a), 1'b0, dc}, 1'b1);
      else    send_cmd({1'b0, 6'(a), 1'b0, 8'h00}, 1'b0);
      for (int j = 0; j < n; j++) begin
         spi_bits(8'hA5, 8, rx);
         chk(tag, rx, ev[j]);
      end
      cs_end();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] rx;
      for (int i = 0; i < 64; i++)   sh_mem[i] = 8'(i * 29 + 3);
      for (int i = 0; i < 1024; i++) lg_mem[i] = 8'(i * 7 + 101) ^ 8'(i >> 8);
      rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset miso", miso, 0);
      chk("R9 reset write strobe", reg_wr_en, 0);
      chk("R9 reset read strobe", reg_rd_en, 0);

      // R1 R3 single short write, then read it back
      wbuf = '{8'hA7};
      do_write(1'b0, 'h15, 4'h0);
      do_read(1'b0, 'h15, 1, 4'h0, "R1 R4 R6 short read");
      do_read(1'b0, 'h20, 3, 4'h0, "R4 R6 short burst read");

      // R5 short wrap on write and read
      wbuf = '{8'h11, 8'h22, 8'h33};
      do_write(1'b0, 62, 4'h0);
      do_read(1'b0, 62, 3, 4'h0, "R5 short wrap read");

      // R2 R3 transmit frame into long space, don't-care bits set
      wbuf = '{8'h00, 8'h04, 8'hDE, 8'hAD, 8'hBE, 8'hEF};
      do_write(1'b1, 'h000, 4'hF);
      do_read(1'b1, 'h000, 6, 4'hA, "R2 R4 long burst read");
      do_read(1'b1, 'h300, 5, 4'h5, "R2 R6 receive area read");

      // R5 long wrap
      wbuf = '{8'h5A, 8'hC3, 8'h96};
      do_write(1'b1, 'h3FE, 4'h7);
      do_read(1'b1, 'h3FF, 2, 4'h0, "R5 long wrap read");

      // R7 abort inside a data byte: no write, value kept
      cs_start();
      spi_bits({1'b0, 6'd5, 1'b1}, 8, rx);
      spi_bits(8'hFF, 5, rx);
      cs_end();
      do_read(1'b0, 5, 1, 4'h0, "R7 partial byte ignored");

      // R7 abort inside short and long command bytes
      cs_start();
      spi_bits(8'h80, 3, rx);
      cs_end();
      wbuf = '{8'h3C};
      do_write(1'b0, 7, 4'h0);
      cs_start();
      spi_bits(8'h9F, 8, rx);
      cs_end();
      do_read(1'b0, 7, 1, 4'h0, "R7 parser reset after abort");

      summary();
      $finish;
   end
endmodule